// File: doc/BRIEF.md
# Four-Bit Accumulator Slice with Hex Display

This block is a small accumulator datapath. A 4-bit register holds the running value. That value is operand A of a 4-bit ALU. The second ALU operand comes from an input port, and a 2-bit opcode picks one of four functions. The ALU result is written back into the register. This closes a loop, so each step works on the result of the step before it.

The register does not load on every system clock. A divider counts system clock cycles and raises a one-cycle enable pulse once every `DIV` cycles. With the default ratio this is one step per second from a 50 MHz clock. For a 100 MHz clock, set `DIV` to 100,000,000. All logic runs on the single system clock.

The register value drives a combinational hexadecimal seven-segment decoder. This lets each step be watched on one digit. The reset input is active low and asynchronous. It clears the accumulator at once. Its release is synchronised to the clock over two flops.

Top module: `acc_slice`

## Requirements
- R1: While `rst_n` is low, the accumulator is cleared to 0 with no clock edge needed, so `seg_n` shows the pattern for 0.
- R2: On a step with `op_sel` = 2'b00, the accumulator keeps its value.
- R3: On a step with `op_sel` = 2'b01, the accumulator becomes its value plus 1, modulo 16 (15 steps to 0).
- R4: On a step with `op_sel` = 2'b10, the accumulator becomes its value plus `operand_b`, modulo 16, and no carry is kept.
- R5: On a step with `op_sel` = 2'b11, the accumulator becomes the bitwise AND of its value and `operand_b`.
- R6: After `rst_n` rises, two clock edges pass before counting starts. Steps then happen on exactly one clock edge in every `DIV`, the first on the `DIV`-th counting edge. Between steps the accumulator holds, whatever `op_sel` and `operand_b` do.
- R7: `seg_n` is active low, with bit 0 = segment a through bit 6 = segment g. It follows the accumulator combinationally. In active-high gfedcba hex, the patterns for values 0..F are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand_b | input | 4 | Second ALU operand |
| op_sel | input | 2 | ALU function select |
| seg_n | output | 7 | Active-low seven-segment pattern, bit 0 = a |

## Verification
The assertions assume that `op_sel` and `operand_b` hold steady around the enable edge. They also assume that reset release comes through the internal synchroniser, so the divider and the accumulator leave reset together.

The bench changes its inputs a little after each rising edge, never at an edge. It shrinks `DIV` to 5 so that many steps fit in a short run. It keeps the reference model's step counter aligned with the two-edge release.

The stimulus changes the opcode and operand between steps to show that they are ignored there. It drives increments and additions past 15 so that the wrap is exercised. It also pulls reset low in the middle of an interval.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DATA_W = 4;

  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_INC  = 2'b01,
    OP_ADD  = 2'b10,
    OP_AND  = 2'b11
  } acc_op_e;
endpackage

// File: rtl/acc_tick_div.sv
module acc_tick_div #(
  parameter int DIV = 50_000_000
) (
  input  logic clk,
  input  logic srst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    if (at_last) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick = at_last;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   func,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (acc_op_e'(func))
      OP_PASS: res = opa;
      OP_INC:  res = opa + W'(1);
      OP_ADD:  res = opa + opb;
      OP_AND:  res = opa & opb;
      default: res = opa;
    endcase
  end
endmodule

// File: rtl/acc_hex7.sv
module acc_hex7 (
  input  logic [3:0] nib,
  output logic [6:0] seg_n
);
  logic [6:0] lit;

  always_comb begin
    case (nib)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
  end

  assign seg_n = ~lit;
endmodule

// File: rtl/acc_slice.sv
module acc_slice
  import acc_pkg::*;
#(
  parameter int DIV = 50_000_000,
  parameter int W   = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] operand_b,
  input  logic [1:0]   op_sel,
  output logic [6:0]   seg_n
);
  logic         rs_q1, srst_n;
  logic         tick;
  logic [W-1:0] acc_q, acc_d, alu_res;

  // reset: asserts at once, releases after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rs_q1  <= 1'b1;
      srst_n <= rs_q1;
    end
  end

  acc_tick_div #(.DIV(DIV)) u_div (
    .clk    (clk),
    .srst_n (srst_n),
    .tick   (tick)
  );

  acc_alu #(.W(W)) u_alu (
    .opa  (acc_q),
    .opb  (operand_b),
    .func (op_sel),
    .res  (alu_res)
  );

  always_comb begin
    acc_d = acc_q;
    if (tick) acc_d = alu_res;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  acc_hex7 u_hex (
    .nib   (acc_q[3:0]),
    .seg_n (seg_n)
  );
endmodule

// File: rtl/acc_slice_chk.sv
module acc_slice_chk #(
  parameter int DIV = 50_000_000,
  parameter int W   = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         srst_n,
  input logic         tick,
  input logic [1:0]   op_sel,
  input logic [W-1:0] operand_b,
  input logic [W-1:0] acc_q
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) + 1 : 2;

  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)   since <= '0;
    else if (tick) since <= '0;
    else           since <= since + 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_n) assert_reset_clear_R1: assert (acc_q == '0);
  end

  assert_pass_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (tick && op_sel == 2'b00) |=> acc_q == $past(acc_q));

  assert_inc_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (tick && op_sel == 2'b01) |=> acc_q == W'($past(acc_q) + W'(1)));

  assert_add_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (tick && op_sel == 2'b10) |=> acc_q == W'($past(acc_q) + $past(operand_b)));

  assert_and_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (tick && op_sel == 2'b11) |=> acc_q == ($past(acc_q) & $past(operand_b)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!srst_n)
    !tick |=> $stable(acc_q));

  assert_period_R6: assert property (@(posedge clk) disable iff (!srst_n)
    tick |-> (since == CW'(DIV - 1)));

  assert_gap_R6: assert property (@(posedge clk) disable iff (!srst_n)
    since < CW'(DIV));
endmodule

bind acc_slice acc_slice_chk #(.DIV(DIV), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srst_n    (srst_n),
  .tick      (tick),
  .op_sel    (op_sel),
  .operand_b (operand_b),
  .acc_q     (acc_q)
);

// File: tb/acc_slice_test.sv
module acc_slice_test;
  localparam int DIV = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] operand_b = 4'd0;
  logic [1:0] op_sel = 2'b00;
  logic [6:0] seg_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int    m_sync = 0;
  int    m_div = 0;
  int    m_acc = 0;
  string m_tag = "R1";

  acc_slice #(.DIV(DIV)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .operand_b (operand_b),
    .op_sel    (op_sel),
    .seg_n     (seg_n)
  );

  always #5 clk = ~clk;

  function automatic logic [6:0] exp_seg(int v);
    logic [6:0] p;
    case (v & 15)
      0: p = 7'h3F;  1: p = 7'h06;  2: p = 7'h5B;  3: p = 7'h4F;
      4: p = 7'h66;  5: p = 7'h6D;  6: p = 7'h7D;  7: p = 7'h07;
      8: p = 7'h7F;  9: p = 7'h6F; 10: p = 7'h77; 11: p = 7'h7C;
      12: p = 7'h39; 13: p = 7'h5E; 14: p = 7'h79; default: p = 7'h71;
    endcase
    return ~p;
  endfunction

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: seg_n actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: two-edge release, step every DIV edges
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_div = 0; m_acc = 0; m_tag = "R1";
    end else if (m_sync < 2) begin
      m_sync++;
    end else if (m_div == DIV - 1) begin
      m_div = 0;
      case (op_sel)
        2'b00: m_tag = "R2";
        2'b01: begin m_acc = m_acc + 1; m_tag = "R3"; end
        2'b10: begin m_acc = m_acc + operand_b; m_tag = "R4"; end
        default: begin m_acc = m_acc & operand_b; m_tag = "R5"; end
      endcase
      m_acc = m_acc & 15;
    end else begin
      m_div++;
      m_tag = "R6";
    end
  end

  always @(negedge clk) begin
    if (!done) check({m_tag, "/R7"}, seg_n, exp_seg(m_acc));
  end

  task automatic drive(logic [1:0] op, logic [3:0] b, int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #2;
      op_sel = op; operand_b = b;
    end
  endtask

  initial begin
    #1 check("R1 reset state", seg_n, exp_seg(0));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R6: first step waits two sync edges plus DIV counting edges
    repeat (DIV + 1) @(posedge clk);
    #3 check("R6 no step before first tick", seg_n, exp_seg(0));
    drive(2'b01, 4'd0, 20 * DIV);          // R3 increments past 15 to wrap
    drive(2'b10, 4'd7, 9 * DIV);           // R4 addition with wrap
    drive(2'b11, 4'b0110, 2 * DIV);        // R5 AND
    drive(2'b10, 4'd15, 3 * DIV);          // R4 add 15 == minus 1
    for (int k = 0; k < 6 * DIV; k++) begin // R6 inputs wiggle between ticks
      @(posedge clk); #2;
      op_sel = 2'(k); operand_b = 4'(k * 3 + 1);
    end
    drive(2'b00, 4'd9, 4 * DIV);           // R2 pass holds
    // R1: asynchronous clear mid-interval, no clock edge needed
    drive(2'b01, 4'd0, 7 * DIV + 2);
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1 check("R1 async clear", seg_n, exp_seg(0));
    @(posedge clk); #2;
    rst_n = 1'b1;
    drive(2'b01, 4'd0, 18 * DIV);          // R3 after reset release, R6 alignment
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule